// File: doc/BRIEF.md
# PCM Peak Level Meter with Serial Readout

This block watches a stream of signed stereo PCM samples, keeps the largest magnitude seen, and sends that value out over a slow serial readout port. A reader clocks out a fixed 96-bit frame. The first 80 bits are a subcode word that arrives on a parallel input from outside the block. The last 16 bits are the meter word: a 15-bit magnitude followed by one channel flag bit.

The block has two modes. In level mode it measures one channel at a time. Each completed readout clears the reading and switches to the other channel, so successive frames alternate between left and right. In peak mode it holds the largest magnitude from either channel. A readout does not disturb that value. Only an explicit clear or the mute input brings it back to zero.

The readout clock is oversampled in the system clock domain. It idles high. The block changes its data output after each falling edge, and the reader samples the output on the rising edge.

Top module: `pcm_peak_meter`

## Requirements
- R1: A frame is 96 readout-clock pulses. The frame content is captured at the first falling edge, and the data output moves to the next bit after each later falling edge. Bit order: `subcode[0]` through `subcode[79]`, then magnitude bits 0 to 14, then the flag bit last.
- R2: A sample's magnitude is the absolute value of its 16-bit two's-complement value. The value -32768 saturates to 0x7FFF.
- R3: In level mode (`peakMode`=0), only samples whose `sampleLeft` matches the selected channel are measured. The flag bit is 1 when left is selected and 0 when right is selected.
- R4: In level mode, a completed frame (the 96th rising edge) clears the magnitude and switches the selected channel.
- R5: In peak mode (`peakMode`=1), samples from both channels are measured and the flag bit is always 0.
- R6: In peak mode, a completed frame leaves the held magnitude unchanged.
- R7: While `holdCtl` is 2'b00 or `muteIn` is 1, the magnitude is cleared, in either mode.
- R8: A sample that arrives in the same cycle as a clear is compared against zero, so the magnitude after the clear equals that sample's magnitude.
- R9: After reset the data output is 0, the magnitude is 0 and the left channel is selected.
- R10: The held magnitude only grows: a later, smaller sample leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | A PCM sample is present this cycle |
| sampleData | input | 16 | Signed two's-complement PCM sample |
| sampleLeft | input | 1 | 1: the sample is from the left channel, 0: from the right channel |
| peakMode | input | 1 | 0: level mode, 1: peak mode |
| holdCtl | input | 2 | Peak control; the value 2'b00 clears the magnitude |
| muteIn | input | 1 | Mute; clears the magnitude while high |
| rdClk | input | 1 | Readout clock, idles high |
| subcode | input | 80 | Subcode word placed at the start of each frame |
| sdo | output | 1 | Serial readout data |

## Verification
The bench aims at the -32768 sample. A design without saturation would report 0 or wrap the 15-bit field. The bench checks that the channel alternates and the reading clears across level-mode frames. A design that forgot either step would repeat the left reading or carry the old maximum into the next frame. In peak mode the bench reads twice in a row and expects identical values, which catches a design that clears on readout. It also checks that the flag bit stays 0 in that mode. Finally, the bench drives a sample in the same cycle as a mute pulse. A design that gave the clear priority would lose that sample and report zero.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // Strobes from readout control to the datapath, one cycle wide each
  typedef struct packed {
    logic load;   // first falling edge of a frame: capture the frame
    logic shift;  // later falling edge: advance to the next bit
    logic done;   // last rising edge: frame complete
  } rdStrobe_t;
endpackage

// File: rtl/pm_readout_ctl.sv
module pm_readout_ctl
  import pm_pkg::*;
#(
  parameter int FRAME_W = 96
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdClk,
  output rdStrobe_t strb
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [1:0]       rdSync;
  logic             rdPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             fallEdge, riseEdge;

  assign fallEdge = rdPrev & ~rdSync[1];
  assign riseEdge = ~rdPrev & rdSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSync <= 2'b11;
      rdPrev <= 1'b1;
      bitCnt <= '0;
    end else begin
      rdSync <= {rdSync[0], rdClk};
      rdPrev <= rdSync[1];
      if (riseEdge) begin
        if (bitCnt == LAST) bitCnt <= '0;
        else                bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load  = fallEdge && (bitCnt == '0);
    strb.shift = fallEdge && (bitCnt != '0);
    strb.done  = riseEdge && (bitCnt == LAST);
  end

  // R1
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> bitCnt == '0);
endmodule

// File: rtl/pm_meter_dp.sv
module pm_meter_dp
  import pm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SUB_W    = 80
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdStrobe_t           strb,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleLeft,
  input  logic                peakMode,
  input  logic [1:0]          holdCtl,
  input  logic                muteIn,
  input  logic [SUB_W-1:0]    subcode,
  output logic                sdo
);
  localparam int MAG_W   = SAMPLE_W - 1;
  localparam int FRAME_W = SUB_W + SAMPLE_W;
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  logic [MAG_W-1:0]   mag, magNext, sampleMag, baseMag;
  logic               chanLeft, nextChan, levelFlip, clearNow, accept;
  logic [FRAME_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] negData;

  // magnitude with saturation of the most negative code
  always_comb begin
    negData = -sampleData;
    if (!sampleData[SAMPLE_W-1])
      sampleMag = sampleData[MAG_W-1:0];
    else if (negData[SAMPLE_W-1])
      sampleMag = MAG_MAX;
    else
      sampleMag = negData[MAG_W-1:0];
  end

  always_comb begin
    clearNow  = muteIn || (holdCtl == 2'b00);
    levelFlip = strb.done && !peakMode;
    nextChan  = levelFlip ? ~chanLeft : chanLeft;
    baseMag   = (clearNow || levelFlip) ? '0 : mag;
    accept    = sampleValid && (peakMode || (sampleLeft == nextChan));
    magNext   = (accept && (sampleMag > baseMag)) ? sampleMag : baseMag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mag      <= '0;
      chanLeft <= 1'b1;
      shiftReg <= '0;
    end else begin
      mag      <= magNext;
      chanLeft <= nextChan;
      if (strb.load)
        shiftReg <= {(peakMode ? 1'b0 : chanLeft), mag, subcode};
      else if (strb.shift)
        shiftReg <= {1'b0, shiftReg[FRAME_W-1:1]};
    end
  end

  assign sdo = shiftReg[0];

  // R10
  hold_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearNow && !levelFlip) |=> mag >= $past(mag));

  // R4
  level_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelFlip && !sampleValid && !clearNow) |=> mag == '0);

  // R4
  level_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelFlip |=> chanLeft != $past(chanLeft));

  // R6
  peak_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && peakMode && !clearNow) |=> mag >= $past(mag));

  // R5
  peak_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && peakMode) |=> shiftReg[FRAME_W-1] == 1'b0);

  // R1
  sdo_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(sdo));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearNow && !sampleValid) |=> mag == '0);
endmodule

// File: rtl/pcm_peak_meter.sv
module pcm_peak_meter
  import pm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SUB_W    = 80
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleLeft,
  input  logic                peakMode,
  input  logic [1:0]          holdCtl,
  input  logic                muteIn,
  input  logic                rdClk,
  input  logic [SUB_W-1:0]    subcode,
  output logic                sdo
);
  localparam int FRAME_W = SUB_W + SAMPLE_W;

  rdStrobe_t strb;

  pm_readout_ctl #(.FRAME_W(FRAME_W)) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .rdClk (rdClk),
    .strb  (strb)
  );

  pm_meter_dp #(.SAMPLE_W(SAMPLE_W), .SUB_W(SUB_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .sampleLeft  (sampleLeft),
    .peakMode    (peakMode),
    .holdCtl     (holdCtl),
    .muteIn      (muteIn),
    .subcode     (subcode),
    .sdo         (sdo)
  );
endmodule

// File: tb/pcm_peak_meter_bench.sv
module pcm_peak_meter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic        sampleLeft = 1'b0;
  logic        peakMode = 1'b0;
  logic [1:0]  holdCtl = 2'b11;
  logic        muteIn = 1'b0;
  logic        rdClk = 1'b1;
  logic [79:0] subcode = '0;
  logic        sdo;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  pcm_peak_meter u_pcm_peak_meter (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleLeft(sampleLeft), .peakMode(peakMode), .holdCtl(holdCtl),
    .muteIn(muteIn), .rdClk(rdClk), .subcode(subcode), .sdo(sdo)
  );

  task automatic check(input string req, input logic [79:0] got, input logic [79:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pushSample(input logic left, input logic [15:0] val);
    @(negedge clk);
    sampleValid = 1'b1; sampleLeft = left; sampleData = val;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // R1: reads one 96-bit frame, sampling before each rising edge
  task automatic readFrame(output logic [95:0] got);
    got = '0;
    for (int i = 0; i < 96; i++) begin
      @(negedge clk); rdClk = 1'b0;
      repeat (6) @(negedge clk);
      got[i] = sdo;
      rdClk = 1'b1;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input string req, input logic flag, input logic [14:0] mag,
                            input logic [79:0] sub);
    logic [95:0] got;
    subcode = sub;
    readFrame(got);
    check({req, " meter word"}, {63'd0, got[95], got[94:80]}, {63'd0, flag, mag});
    check({req, " subcode (R1)"}, got[79:0], sub);
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    check("R9 sdo after reset", {79'd0, sdo}, 80'd0);
    checkFrame("R9 reset left/zero", 1'b1, 15'd0, 80'hA5A5_0123_4567_89AB_CDEF);
  endtask

  task automatic testLevel;
    // after the reset frame the right channel is selected (R4)
    pushSample(1'b1, 16'd20000);
    pushSample(1'b0, -16'sd32768);
    pushSample(1'b0, 16'd100);
    checkFrame("R2 R3 right saturated", 1'b0, 15'h7FFF, 80'hFFFF_0000_FFFF_0000_1234);
    pushSample(1'b1, 16'd100);
    pushSample(1'b0, 16'd5000);
    pushSample(1'b1, -16'sd300);
    pushSample(1'b1, 16'd50);
    checkFrame("R3 R10 left max", 1'b1, 15'd300, 80'h0F0F_1E1E_2D2D_3C3C_4B4B);
    checkFrame("R4 cleared after read", 1'b0, 15'd0, 80'h8000_0000_0000_0000_0001);
  endtask

  task automatic testPeak;
    peakMode = 1'b1;
    pushSample(1'b1, 16'd1000);
    pushSample(1'b0, -16'sd7000);
    pushSample(1'b1, 16'd300);
    checkFrame("R5 both channels", 1'b0, 15'd7000, 80'h1357_9BDF_2468_ACE0_1122);
    checkFrame("R6 held after read", 1'b0, 15'd7000, 80'h3344_5566_7788_99AA_BBCC);
  endtask

  task automatic testClear;
    @(negedge clk); holdCtl = 2'b00;
    @(negedge clk); holdCtl = 2'b11;
    checkFrame("R7 control clear", 1'b0, 15'd0, 80'h0000_1111_2222_3333_4444);
    pushSample(1'b0, 16'd9000);
    @(negedge clk);
    muteIn = 1'b1; sampleValid = 1'b1; sampleLeft = 1'b1; sampleData = -16'sd1234;
    @(negedge clk);
    muteIn = 1'b0; sampleValid = 1'b0;
    checkFrame("R8 sample with mute", 1'b0, 15'd1234, 80'h5555_6666_7777_8888_9999);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLevel();
    testPeak();
    testClear();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule